// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive half of a serial port that acts as clock master. It drives the shift clock on its clock output and reads the serial data input, which it never drives. A programmable divider sets how long each clock level lasts. While a receive request is active, the block produces clock pulses. On the falling (trailing) edge of each pulse it samples the data input into a shift register, least significant bit first.

There are two kinds of request. A one-shot request is armed by a pulse on `single_set`, collects exactly one character and then disarms itself. A continuous request is a level on `cont_en`; characters follow one another back to back for as long as it is held. A character is 8 or 9 bits long. Each finished character is handed downstream as a parallel word with a one-cycle valid strobe. The downstream buffer can hold off further clocking with `stall`.

Top module: `sync_master_rx`

## Requirements
- R1: After reset, and whenever no request is active, `sclk_out`, `char_valid` and `single_pending` are 0. A rising clock edge only appears while `port_en` is 1, a request is active and `stall` is 0.
- R2: Each high phase and each low phase of `sclk_out` lasts `divisor`+1 system clock cycles, so one bit period is 2*(`divisor`+1) cycles.
- R3: A one-shot request with `cont_en` low produces exactly 8 (or 9) rising clock edges and exactly one valid word, then clears `single_pending`.
- R4: While `cont_en` is 1, characters are received back to back without a break in clocking, and each one yields its own word.
- R5: If the active request disappears in the middle of a character, `sclk_out` is low in the next cycle. No rising edge follows, and the partial character is dropped with no strobe.
- R6: With both requests active, `single_pending` clears when the first character completes, and reception goes on under the continuous request.
- R7: Data is sampled on the trailing edge of each clock pulse and shifted in least significant bit first. The first bit received is word bit 0. In 8-bit mode, word bit 8 is 0.
- R8: When `nine_bit` is 1, a character has 9 clock pulses, and the ninth bit received is word bit 8.
- R9: While `stall` is 1 (with `port_en` high and a request active), `sclk_out` keeps its level and no character starts. Reception resumes where it left off after `stall` drops.
- R10: Dropping `port_en` aborts any reception. In the next cycle `sclk_out` and `single_pending` are 0, and no word is emitted for the aborted character.
- R11: A `single_set` pulse in the same cycle as the completion of a one-shot character re-arms the request. `single_pending` stays 1 and a second character follows.
- R12: `char_valid` is high for exactly one cycle per character, in the cycle in which `sclk_out` has just dropped for the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| port_en | input | 1 | Serial port enable; low aborts and idles |
| cont_en | input | 1 | Continuous receive request (level) |
| single_set | input | 1 | One-cycle pulse that arms a one-shot request |
| nine_bit | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit |
| stall | input | 1 | Downstream hold: freezes clock generation |
| divisor | input | 16 | Phase length minus one, in system clocks |
| sdata_in | input | 1 | Serial data input |
| sclk_out | output | 1 | Generated shift clock, idle low |
| char_data | output | 9 | Received word, valid with char_valid |
| char_valid | output | 1 | One-cycle strobe per finished character |
| single_pending | output | 1 | One-shot request still armed |

## Verification
The one-shot request can be cleared by completion and re-armed by a new `single_set` pulse in the same cycle. The arming pulse takes priority. The bench provokes this by counting rising clock edges of a one-shot character and then placing the pulse exactly `divisor` cycles after the last rising edge. That puts it in the cycle whose closing edge retires the character. The bench then judges the outcome: `single_pending` must stay high when the first word arrives, and a second complete word must follow from the next stretch of serial data. A request dropped at the instant of a trailing edge is a related clash, in which the abort wins and the character is discarded.

// File: rtl/smrx_pkg.sv
package smrx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/smrx_phase_timer.sv
module smrx_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = advance && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (advance) begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Phase length bounded by the programmed limit (R2)
  assert_phase_within_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (cnt_q <= limit));
endmodule

// File: rtl/smrx_shifter.sv
module smrx_shifter #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              din,
  input  logic              wide,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (clear)         sr_d = '0;
    else if (shift_en) sr_d = {din, sr_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  // Narrow characters end one position higher; realign so the first bit is bit 0.
  assign word = wide ? sr_q : {1'b0, sr_q[DATA_W-1:1]};
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
  import smrx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              cont_en,
  input  logic              single_set,
  input  logic              nine_bit,
  input  logic              stall,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              sdata_in,
  output logic              sclk_out,
  output logic [DATA_W-1:0] char_data,
  output logic              char_valid,
  output logic              single_pending
);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_WIDE   = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] LAST_NARROW = BIT_W'(DATA_W - 2);

  rx_state_e        state_q, state_d;
  logic [BIT_W-1:0] bits_q, bits_d;
  logic             single_q, single_d;
  logic             valid_q, valid_d;
  logic             sck_q, sck_d;

  logic want, running, abort, advance, start, tick, sample, last_bit, complete;

  assign want     = single_q | cont_en;
  assign running  = (state_q != ST_IDLE);
  assign abort    = running & (~port_en | ~want);
  assign advance  = running & ~abort & ~stall;
  assign start    = ~running & port_en & want & ~stall;
  assign last_bit = (bits_q == (nine_bit ? LAST_WIDE : LAST_NARROW));
  assign sample   = tick & (state_q == ST_HIGH);
  assign complete = sample & last_bit;

  smrx_phase_timer #(.CNT_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (~running),
    .advance (advance),
    .limit   (divisor),
    .tick    (tick)
  );

  smrx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .shift_en (sample),
    .din      (sdata_in),
    .wide     (nine_bit),
    .word     (char_data)
  );

  always_comb begin
    state_d = state_q;
    bits_d  = bits_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_HIGH;
          bits_d  = '0;
        end
      end
      ST_HIGH: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (tick) begin
          state_d = ST_LOW;
          bits_d  = last_bit ? '0 : bits_q + 1'b1;
        end
      end
      ST_LOW: begin
        if (abort)     state_d = ST_IDLE;
        else if (tick) state_d = ST_HIGH;
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_d == ST_IDLE) bits_d = '0;
  end

  always_comb begin
    if (!port_en)        single_d = 1'b0;
    else if (single_set) single_d = 1'b1;
    else if (complete)   single_d = 1'b0;
    else                 single_d = single_q;
    valid_d = complete;
    sck_d   = (state_d == ST_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bits_q   <= '0;
      single_q <= 1'b0;
      valid_q  <= 1'b0;
      sck_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      bits_q   <= bits_d;
      single_q <= single_d;
      valid_q  <= valid_d;
      sck_q    <= sck_d;
    end
  end

  assign sclk_out       = sck_q;
  assign char_valid     = valid_q;
  assign single_pending = single_q;

  // A rising clock edge needs an enabled port, a request and no stall (R1)
  assert_edge_needs_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_out) |-> $past(port_en && want && !stall));

  // A vanished request silences the clock and drops the character (R5)
  assert_drop_stops_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !want) |=> (!sclk_out && !char_valid));

  // Stall holds the clock level (R9)
  assert_stall_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && want && stall) |=> $stable(sclk_out));

  // Port disable idles the block (R10)
  assert_disable_aborts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!sclk_out && !single_pending));

  // One-shot request retires with its character unless re-armed (R3)
  assert_single_retires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !$past(single_set)) |-> !single_pending);

  // Strobe is a single cycle wide (R12)
  assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid);
endmodule

// File: tb/sync_master_rx_tb.sv
module sync_master_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0, cont_en = 1'b0, single_set = 1'b0;
  logic       nine_bit = 1'b0, stall = 1'b0;
  logic [15:0] divisor = 16'd0;
  logic       sdata_in = 1'b0;
  logic       sclk_out, char_valid, single_pending;
  logic [8:0] char_data;

  sync_master_rx u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cont_en(cont_en),
    .single_set(single_set), .nine_bit(nine_bit), .stall(stall),
    .divisor(divisor), .sdata_in(sdata_in), .sclk_out(sclk_out),
    .char_data(char_data), .char_valid(char_valid),
    .single_pending(single_pending)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [63:0] stream = '0;
  int sidx = 0;
  int rises = 0, highc = 0, nvalid = 0, vt_err = 0;
  logic sck_prev = 1'b0, valid_prev = 1'b0;
  logic [8:0] got [0:7];

  // Serial source: next bit presented just after each rising clock edge
  always @(posedge sclk_out) begin
    #1;
    sdata_in = stream[sidx & 63];
    sidx++;
  end

  // Monitor sampled away from the active edge
  always @(negedge clk) begin
    if (sclk_out && !sck_prev) rises++;
    if (sclk_out) highc++;
    if (char_valid) begin
      if (nvalid < 8) got[nvalid] = char_data;
      nvalid++;
      if (valid_prev || !(sck_prev && !sclk_out)) vt_err++;
    end
    sck_prev   = sclk_out;
    valid_prev = char_valid;
  end

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  function automatic logic [8:0] exp_word(int start, bit nine);
    logic [8:0] w = '0;
    int n = nine ? 9 : 8;
    for (int i = 0; i < n; i++) w[i] = stream[start + i];
    return w;
  endfunction

  task automatic prep(int dv, bit nine);
    divisor  = 16'(dv);
    nine_bit = nine;
    stream   = {$urandom, $urandom};
    sidx = 0; rises = 0; highc = 0; nvalid = 0;
  endtask

  task automatic pulse_single();
    single_set = 1'b1;
    step();
    single_set = 1'b0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 3000 && (single_pending || sclk_out || cont_en); g++) step();
    step(4);
  endtask

  task automatic wait_rises(int target);
    for (int g = 0; g < 3000 && rises < target; g++) step();
  endtask

  task automatic wait_valid(int target);
    for (int g = 0; g < 3000 && nvalid < target; g++) step();
  endtask

  task automatic one_shot(int dv, bit nine);
    int n = nine ? 9 : 8;
    prep(dv, nine);
    pulse_single();
    wait_idle();
    chk(rises == n, "R3 edge count", rises, n);
    chk(highc == n * (dv + 1), "R2 high-phase cycles", highc, n * (dv + 1));
    chk(nvalid == 1, "R3 word count", nvalid, 1);
    chk(!single_pending, "R3 request retired", single_pending, 0);
    if (nine) chk(got[0] == exp_word(0, 1), "R8 nine-bit word", got[0], exp_word(0, 1));
    else      chk(got[0] == exp_word(0, 0), "R7 eight-bit word", got[0], exp_word(0, 0));
  endtask

  initial begin
    #600000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, r, d;
    logic s;
    void'($urandom(32'd7151));
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(sclk_out == 0, "R1 reset clock", sclk_out, 0);
    chk(char_valid == 0, "R1 reset strobe", char_valid, 0);
    chk(single_pending == 0, "R1 reset request", single_pending, 0);
    port_en = 1'b1;
    prep(0, 0);
    step(20);
    chk(rises == 0, "R1 no request no edges", rises, 0);

    // Directed: both widths at the fastest and a slow divider
    one_shot(0, 0);
    one_shot(0, 1);
    one_shot(5, 0);
    one_shot(3, 1);

    // Continuous reception with a mid-character drop (R4, R5)
    prep(1, 0);
    n = 8;
    cont_en = 1'b1;
    wait_rises(3 * n + 2);
    cont_en = 1'b0;
    step();
    chk(sclk_out == 0, "R5 clock stops", sclk_out, 0);
    step(40);
    chk(rises == 3 * n + 2, "R5 no further edges", rises, 3 * n + 2);
    chk(nvalid == 3, "R5 partial discarded", nvalid, 3);
    for (int k = 0; k < 3; k++)
      chk(got[k] == exp_word(k * n, 0), "R4 back-to-back word", got[k], exp_word(k * n, 0));

    // Both requests (R6)
    prep(2, 1);
    n = 9;
    cont_en = 1'b1;
    pulse_single();
    wait_valid(1);
    chk(single_pending == 0, "R6 one-shot retired", single_pending, 1'b0);
    wait_valid(2);
    chk(sclk_out == 0, "R6 still running", sclk_out, 0);
    wait_rises(2 * n + 1);
    cont_en = 1'b0;
    wait_idle();
    chk(nvalid == 2, "R6 word count", nvalid, 2);
    chk(got[1] == exp_word(n, 1), "R6 second word", got[1], exp_word(n, 1));

    // Re-arm in the completion cycle (R11)
    d = $urandom_range(0, 3);
    prep(d, 0);
    n = 8;
    pulse_single();
    wait_rises(n);
    step(d);
    pulse_single();
    wait_valid(1);
    chk(single_pending == 1, "R11 re-armed", single_pending, 1);
    wait_idle();
    chk(nvalid == 2, "R11 second character", nvalid, 2);
    chk(rises == 2 * n, "R11 edge count", rises, 2 * n);
    chk(got[1] == exp_word(n, 0), "R11 second word", got[1], exp_word(n, 0));

    // Stall before start and mid-character (R9)
    prep(1, 0);
    stall = 1'b1;
    pulse_single();
    step(20);
    chk(rises == 0 && sclk_out == 0, "R9 no start under stall", rises, 0);
    stall = 1'b0;
    wait_rises(3);
    step($urandom_range(0, 2));
    stall = 1'b1;
    s = sclk_out;
    r = rises;
    step(30);
    chk(sclk_out == s, "R9 level held", sclk_out, s);
    chk(rises == r, "R9 edges held", rises, r);
    stall = 1'b0;
    wait_idle();
    chk(nvalid == 1 && got[0] == exp_word(0, 0), "R9 resumed word", got[0], exp_word(0, 0));

    // Port disable abort (R10)
    prep(2, 1);
    pulse_single();
    wait_rises(2);
    port_en = 1'b0;
    step();
    chk(sclk_out == 0, "R10 clock low", sclk_out, 0);
    chk(single_pending == 0, "R10 request cleared", single_pending, 0);
    step(60);
    chk(nvalid == 0, "R10 no word", nvalid, 0);
    port_en = 1'b1;
    step(2);

    // Random one-shot receptions
    for (int it = 0; it < 16; it++)
      one_shot($urandom_range(0, 4), 1'($urandom_range(0, 1)));

    chk(vt_err == 0, "R12 strobe timing", vt_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule